// File: doc/BRIEF.md
# Cipher Key and IV Context Store

This block holds the cipher configuration written by key and IV commands. An upstream command decoder sends it each command word with its payload already gathered. The block keeps two key contexts and a parameterised number of IV contexts, four by default. A key command records the direction and the chaining mode for its context. It then loads either a user key from the payload or one of a small set of fixed built-in keys. Malformed commands pulse a reject output and change no stored state.

The cipher data path looks up a key context and an IV context at the same time. The lookup is combinational. It returns the key bytes, the key length in bytes, the direction, the chaining mode, the IV, and a flag marking a key length that no cipher can use. A separate store-IV request reads out the four IV words of a context, together with a 40-bit write address formed from the request.

Top module: `ctx_store_top`

## Requirements
- R1: After reset every stored key, key length, IV, direction and mode flag is zero, and `reject` and `sivDone` are low.
- R2: In a key command (`loadIsIv` low), selector bits 26:24 equal to zero load a user key. Length field bits 23:22 give 16, 24 or 32 bytes for codes 0, 1 and 2. The leading payload words (word 0 = bits 31:0) are copied and the remaining key words read as zero. The result is visible on lookup one cycle after the command.
- R3: A key command with selector zero and length code 3 (64 bytes) is rejected and leaves the context unchanged.
- R4: Mode bits 17:16 select ECB (0) or CBC (1). Codes 2 and 3 reject the command, and nothing is changed.
- R5: Bit 20 set stores encrypt and clear stores decrypt. Direction and mode are kept per key context and returned by `lkEncrypt` and `lkCbc`.
- R6: A selector of 1 to 3 loads a 32-byte built-in key whose byte 0 (bits 7:0) equals the selector, with all other bytes zero. The length field and the payload are ignored.
- R7: A selector of 4 to 7 loads an all-zero key of length zero.
- R8: Bit 27 of a key command selects key context 0 or 1, and the other context is left untouched.
- R9: An IV command (`loadIsIv` high) stores payload bits 127:0 into the IV context given by bits 27:26. A context number of `IV_CTX` or more is rejected.
- R10: `lkKeyBad` is high exactly when the looked-up key length is not 16, 24 or 32 bytes.
- R11: When the looked-up key context is in ECB mode, `lkIv` is zero. In CBC mode `lkIv` is the IV of the context selected by `lkIvCtx`.
- R12: A store-IV request whose context (bits 27:26 of `sivCmd`) is in range raises `sivDone` one cycle later. At that point `sivIv` holds that context's IV and `sivAddr` holds `sivCmd[7:0]` in bits 39:32 and `sivAddrLo` in bits 31:0. An out-of-range request gives no `sivDone`.
- R13: `reject` is a one-cycle pulse in the cycle after a rejected key, IV or store-IV command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadValid | input | 1 | Key or IV command present |
| loadIsIv | input | 1 | High for an IV command, low for a key command |
| loadCmd | input | 32 | Command word |
| loadPayload | input | KEY_WORDS*32 | Payload words, word 0 in the low bits |
| sivValid | input | 1 | Store-IV request present |
| sivCmd | input | 32 | Store-IV command word |
| sivAddrLo | input | 32 | Low 32 bits of the store address |
| lkKeyCtx | input | 1 | Key context to look up |
| lkIvCtx | input | 2 | IV context to look up |
| lkKey | output | KEY_WORDS*32 | Key bytes of the looked-up context |
| lkKeyLen | output | 7 | Key length in bytes |
| lkEncrypt | output | 1 | Direction, high for encrypt |
| lkCbc | output | 1 | Chaining mode, high for CBC |
| lkKeyBad | output | 1 | Key length is unusable |
| lkIv | output | IV_WORDS*32 | IV to apply, zero in ECB |
| sivDone | output | 1 | Store-IV result valid |
| sivIv | output | IV_WORDS*32 | IV words for the store |
| sivAddr | output | 40 | Store address |
| reject | output | 1 | Previous command was malformed |

## Verification
The bench builds the block with `IV_CTX` set to 3, while leaving the 2-bit context field in place. With that setting an IV command or store-IV request naming context 3 is really out of range, so the rejection path of R9 and R12 can be reached. With the default of four contexts that path cannot be reached. `KEY_WORDS` stays at 8, so all three usable key lengths and the unsupported 64-byte code can be driven.

// File: rtl/ctx_store_pkg.sv
package ctx_store_pkg;

  typedef struct packed {
    logic       keyWe;
    logic       keyCtx;
    logic [2:0] keySel;
    logic [1:0] lenCode;
    logic       encrypt;
    logic       cbc;
    logic       ivWe;
    logic [1:0] ivCtx;
    logic       sivFire;
    logic [1:0] sivCtx;
  } ctx_strobe_t;

  function automatic logic [6:0] lenBytes(input logic [1:0] code);
    case (code)
      2'd0:    return 7'd16;
      2'd1:    return 7'd24;
      2'd2:    return 7'd32;
      default: return 7'd64;
    endcase
  endfunction

endpackage

// File: rtl/ctx_store_ctrl.sv
module ctx_store_ctrl
  import ctx_store_pkg::*;
#(
  parameter int IV_CTX = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadValid,
  input  logic        loadIsIv,
  input  logic [31:0] loadCmd,
  input  logic        sivValid,
  input  logic [31:0] sivCmd,
  output ctx_strobe_t stb,
  output logic        sivDone,
  output logic        reject
);

  logic modeBad, lenBad, keyOk, ivOk, sivOk, rejectNext;

  always_comb begin
    modeBad = loadCmd[17];
    lenBad  = (loadCmd[26:24] == 3'd0) && (loadCmd[23:22] == 2'd3);
    keyOk   = !modeBad && !lenBad;
    ivOk    = ({30'd0, loadCmd[27:26]} < 32'(IV_CTX));
    sivOk   = ({30'd0, sivCmd[27:26]} < 32'(IV_CTX));

    stb.keyWe   = loadValid && !loadIsIv && keyOk;
    stb.keyCtx  = loadCmd[27];
    stb.keySel  = loadCmd[26:24];
    stb.lenCode = loadCmd[23:22];
    stb.encrypt = loadCmd[20];
    stb.cbc     = loadCmd[16];
    stb.ivWe    = loadValid && loadIsIv && ivOk;
    stb.ivCtx   = loadCmd[27:26];
    stb.sivFire = sivValid && sivOk;
    stb.sivCtx  = sivCmd[27:26];

    rejectNext = (loadValid && !loadIsIv && !keyOk) ||
                 (loadValid && loadIsIv && !ivOk) ||
                 (sivValid && !sivOk);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reject  <= 1'b0;
      sivDone <= 1'b0;
    end else begin
      reject  <= rejectNext;
      sivDone <= stb.sivFire;
    end
  end

  // R4
  bad_mode_rejects_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && !loadIsIv && loadCmd[17]) |=> reject);

  // R12
  siv_done_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    sivDone |-> $past(sivValid));

  // R13
  reject_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    reject |-> ($past(loadValid) || $past(sivValid)));

endmodule

// File: rtl/ctx_store_data.sv
module ctx_store_data
  import ctx_store_pkg::*;
#(
  parameter int KEY_WORDS    = 8,
  parameter int IV_WORDS     = 4,
  parameter int IV_CTX       = 4,
  parameter int BUILTIN_LAST = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctx_strobe_t               stb,
  input  logic [KEY_WORDS*32-1:0]   loadPayload,
  input  logic [7:0]                sivAddrHi,
  input  logic [31:0]               sivAddrLo,
  input  logic                      lkKeyCtx,
  input  logic [1:0]                lkIvCtx,
  output logic [KEY_WORDS*32-1:0]   lkKey,
  output logic [6:0]                lkKeyLen,
  output logic                      lkEncrypt,
  output logic                      lkCbc,
  output logic                      lkKeyBad,
  output logic [IV_WORDS*32-1:0]    lkIv,
  output logic [IV_WORDS*32-1:0]    sivIv,
  output logic [39:0]               sivAddr
);

  localparam int KEY_BITS = KEY_WORDS * 32;
  localparam int IV_BITS  = IV_WORDS * 32;
  localparam int KEY_CTX  = 2;
  localparam logic [6:0] BUILTIN_BYTES = 7'd32;

  logic [KEY_BITS-1:0] keyMem [KEY_CTX];
  logic [6:0]          keyLen [KEY_CTX];
  logic                keyEnc [KEY_CTX];
  logic                keyCbc [KEY_CTX];
  logic [IV_BITS-1:0]  ivMem  [IV_CTX];

  logic [KEY_BITS-1:0] keyNext;
  logic [6:0]          lenNext;

  always_comb begin
    keyNext = '0;
    lenNext = '0;
    if (stb.keySel != 3'd0) begin
      if ({29'd0, stb.keySel} <= 32'(BUILTIN_LAST)) begin
        keyNext[7:0] = {5'd0, stb.keySel};
        lenNext      = BUILTIN_BYTES;
      end
    end else begin
      lenNext = lenBytes(stb.lenCode);
      for (int w = 0; w < KEY_WORDS; w++) begin
        if (32'(w * 4) < {25'd0, lenNext})
          keyNext[w*32 +: 32] = loadPayload[w*32 +: 32];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < KEY_CTX; c++) begin
        keyMem[c] <= '0;
        keyLen[c] <= '0;
        keyEnc[c] <= 1'b0;
        keyCbc[c] <= 1'b0;
      end
      for (int c = 0; c < IV_CTX; c++) ivMem[c] <= '0;
      sivIv   <= '0;
      sivAddr <= '0;
    end else begin
      if (stb.keyWe) begin
        keyMem[stb.keyCtx] <= keyNext;
        keyLen[stb.keyCtx] <= lenNext;
        keyEnc[stb.keyCtx] <= stb.encrypt;
        keyCbc[stb.keyCtx] <= stb.cbc;
      end
      if (stb.ivWe) ivMem[stb.ivCtx] <= loadPayload[IV_BITS-1:0];
      if (stb.sivFire) begin
        sivIv   <= ivMem[stb.sivCtx];
        sivAddr <= {sivAddrHi, sivAddrLo};
      end
    end
  end

  logic [IV_BITS-1:0] ivPick;

  always_comb begin
    lkKey     = keyMem[lkKeyCtx];
    lkKeyLen  = keyLen[lkKeyCtx];
    lkEncrypt = keyEnc[lkKeyCtx];
    lkCbc     = keyCbc[lkKeyCtx];
    lkKeyBad  = !(lkKeyLen == 7'd16 || lkKeyLen == 7'd24 || lkKeyLen == 7'd32);
    ivPick    = ({30'd0, lkIvCtx} < 32'(IV_CTX)) ? ivMem[lkIvCtx] : '0;
    lkIv      = lkCbc ? ivPick : '0;
  end

  // R6
  builtin_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.keyWe && stb.keySel != 3'd0 && {29'd0, stb.keySel} <= 32'(BUILTIN_LAST))
      |=> keyLen[$past(stb.keyCtx)] == BUILTIN_BYTES);

  // R3
  no_long_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkKeyLen <= 7'd32);

  // R9
  iv_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ivWe |=> ivMem[$past(stb.ivCtx)] == $past(loadPayload[IV_BITS-1:0]));

  // R11
  ecb_no_iv_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkCbc |-> lkIv == '0);

endmodule

// File: rtl/ctx_store_top.sv
module ctx_store_top
  import ctx_store_pkg::*;
#(
  parameter int KEY_WORDS    = 8,
  parameter int IV_WORDS     = 4,
  parameter int IV_CTX       = 4,
  parameter int BUILTIN_LAST = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     loadValid,
  input  logic                     loadIsIv,
  input  logic [31:0]              loadCmd,
  input  logic [KEY_WORDS*32-1:0]  loadPayload,
  input  logic                     sivValid,
  input  logic [31:0]              sivCmd,
  input  logic [31:0]              sivAddrLo,
  input  logic                     lkKeyCtx,
  input  logic [1:0]               lkIvCtx,
  output logic [KEY_WORDS*32-1:0]  lkKey,
  output logic [6:0]               lkKeyLen,
  output logic                     lkEncrypt,
  output logic                     lkCbc,
  output logic                     lkKeyBad,
  output logic [IV_WORDS*32-1:0]   lkIv,
  output logic                     sivDone,
  output logic [IV_WORDS*32-1:0]   sivIv,
  output logic [39:0]              sivAddr,
  output logic                     reject
);

  ctx_strobe_t stb;

  ctx_store_ctrl #(.IV_CTX(IV_CTX)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .loadValid(loadValid), .loadIsIv(loadIsIv), .loadCmd(loadCmd),
    .sivValid(sivValid), .sivCmd(sivCmd),
    .stb(stb), .sivDone(sivDone), .reject(reject)
  );

  ctx_store_data #(
    .KEY_WORDS(KEY_WORDS), .IV_WORDS(IV_WORDS),
    .IV_CTX(IV_CTX), .BUILTIN_LAST(BUILTIN_LAST)
  ) u_data (
    .clk(clk), .rstN(rstN), .stb(stb),
    .loadPayload(loadPayload),
    .sivAddrHi(sivCmd[7:0]), .sivAddrLo(sivAddrLo),
    .lkKeyCtx(lkKeyCtx), .lkIvCtx(lkIvCtx),
    .lkKey(lkKey), .lkKeyLen(lkKeyLen), .lkEncrypt(lkEncrypt),
    .lkCbc(lkCbc), .lkKeyBad(lkKeyBad), .lkIv(lkIv),
    .sivIv(sivIv), .sivAddr(sivAddr)
  );

endmodule

// File: tb/sim_ctx_store_top.sv
`timescale 1ns/1ps
module sim_ctx_store_top;

  localparam int KW = 8;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadValid = 1'b0, loadIsIv = 1'b0;
  logic [31:0] loadCmd = '0;
  logic [KW*32-1:0] loadPayload = '0;
  logic sivValid = 1'b0;
  logic [31:0] sivCmd = '0, sivAddrLo = '0;
  logic lkKeyCtx = 1'b0;
  logic [1:0] lkIvCtx = '0;
  logic [KW*32-1:0] lkKey;
  logic [6:0] lkKeyLen;
  logic lkEncrypt, lkCbc, lkKeyBad, sivDone, reject;
  logic [IW*32-1:0] lkIv, sivIv;
  logic [39:0] sivAddr;

  always #5 clk = ~clk;

  ctx_store_top #(.KEY_WORDS(KW), .IV_WORDS(IW), .IV_CTX(3), .BUILTIN_LAST(3)) u0 (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadIsIv(loadIsIv),
    .loadCmd(loadCmd), .loadPayload(loadPayload), .sivValid(sivValid),
    .sivCmd(sivCmd), .sivAddrLo(sivAddrLo), .lkKeyCtx(lkKeyCtx),
    .lkIvCtx(lkIvCtx), .lkKey(lkKey), .lkKeyLen(lkKeyLen),
    .lkEncrypt(lkEncrypt), .lkCbc(lkCbc), .lkKeyBad(lkKeyBad), .lkIv(lkIv),
    .sivDone(sivDone), .sivIv(sivIv), .sivAddr(sivAddr), .reject(reject)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // entry: ctx(1) sel(3) len(2) enc(1) mode(2) expRej(1) expLen(7)
  localparam logic [16:0] VEC [12] = '{
    {1'b0, 3'd0, 2'd0, 1'b1, 2'd0, 1'b0, 7'd16},  // R2
    {1'b1, 3'd0, 2'd1, 1'b0, 2'd1, 1'b0, 7'd24},  // R2 R8
    {1'b0, 3'd0, 2'd2, 1'b0, 2'd1, 1'b0, 7'd32},  // R2
    {1'b0, 3'd0, 2'd3, 1'b1, 2'd0, 1'b1, 7'd32},  // R3
    {1'b1, 3'd0, 2'd0, 1'b1, 2'd2, 1'b1, 7'd24},  // R4
    {1'b1, 3'd0, 2'd0, 1'b1, 2'd3, 1'b1, 7'd24},  // R4
    {1'b1, 3'd2, 2'd3, 1'b1, 2'd1, 1'b0, 7'd32},  // R6
    {1'b0, 3'd5, 2'd0, 1'b0, 2'd0, 1'b0, 7'd0},   // R7
    {1'b0, 3'd1, 2'd0, 1'b1, 2'd0, 1'b0, 7'd32},  // R6
    {1'b0, 3'd3, 2'd0, 1'b0, 2'd1, 1'b0, 7'd32},  // R6
    {1'b1, 3'd7, 2'd2, 1'b1, 2'd0, 1'b0, 7'd0},   // R7
    {1'b1, 3'd0, 2'd0, 1'b0, 2'd0, 1'b0, 7'd16}   // R2
  };

  logic [KW*32-1:0] mKey [2];
  logic mEnc [2], mCbc [2];

  task automatic cycleLoad(input logic isIv, input logic [31:0] cmd, input logic [KW*32-1:0] pl);
    @(negedge clk);
    loadValid = 1'b1; loadIsIv = isIv; loadCmd = cmd; loadPayload = pl;
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  task automatic cycleSiv(input logic [31:0] cmd, input logic [31:0] lo);
    @(negedge clk);
    sivValid = 1'b1; sivCmd = cmd; sivAddrLo = lo;
    @(negedge clk);
    sivValid = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] iv0, iv2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int c = 0; c < 2; c++) begin
      lkKeyCtx = c[0];
      #1;
      chk("R1 key", lkKey, '0);
      chk("R1 len", 256'(lkKeyLen), '0);
      chk("R1 flags", 256'({lkEncrypt, lkCbc}), '0);
      chk("R10 bad at reset", 256'(lkKeyBad), 256'(1));
    end
    chk("R1 outs", 256'({reject, sivDone}), '0);
    for (int c = 0; c < 2; c++) begin mKey[c] = '0; mEnc[c] = 0; mCbc[c] = 0; end

    for (int e = 0; e < 12; e++) begin
      logic [16:0] v;
      logic [KW*32-1:0] pl, ek;
      logic ctx;
      logic [2:0] sel;
      logic [1:0] len, mode;
      v = VEC[e];
      ctx = v[16]; sel = v[15:13]; len = v[12:11]; mode = v[9:8];
      for (int w = 0; w < KW; w++) pl[w*32 +: 32] = {8'(e), 8'hC0, 16'(w + 1)};
      if (!v[7]) begin
        ek = '0;
        if (sel == 0) begin
          for (int w = 0; w < KW; w++)
            if (w * 4 < int'(v[6:0])) ek[w*32 +: 32] = pl[w*32 +: 32];
        end else if (sel <= 3) ek[7:0] = {5'd0, sel};
        mKey[ctx] = ek; mEnc[ctx] = v[10]; mCbc[ctx] = mode[0];
      end
      lkKeyCtx = ctx;
      cycleLoad(1'b0, {4'h1, ctx, sel, len, 1'b0, v[10], 2'b0, mode, 16'h0}, pl);
      #1;
      chk("R13 R3 R4 reject", 256'(reject), 256'(v[7]));
      chk("R2 R6 R7 len", 256'(lkKeyLen), 256'(v[6:0]));
      chk("R2 R6 R7 key", lkKey, mKey[ctx]);
      chk("R5 dir mode", 256'({lkEncrypt, lkCbc}), 256'({mEnc[ctx], mCbc[ctx]}));
      chk("R10 bad flag", 256'(lkKeyBad),
          256'(!(v[6:0] == 16 || v[6:0] == 24 || v[6:0] == 32)));
      lkKeyCtx = ~ctx;
      #1;
      chk("R8 other ctx", lkKey, mKey[~ctx]);
      @(negedge clk);
      chk("R13 pulse ends", 256'(reject), '0);
    end

    // ctx0 now CBC (built-in 3), ctx1 ECB (user 16)
    iv0 = 128'h0123_4567_89AB_CDEF_0F1E_2D3C_4B5A_6978;
    iv2 = 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555;
    cycleLoad(1'b1, {4'h2, 2'd0, 26'd0}, {128'hFFFF, iv0});
    #1 chk("R9 iv ok", 256'(reject), '0);
    cycleLoad(1'b1, {4'h2, 2'd2, 26'd0}, {128'h0, iv2});
    cycleLoad(1'b1, {4'h2, 2'd3, 26'd0}, {128'h0, ~iv2});
    #1 chk("R9 R13 iv ctx range", 256'(reject), 256'(1));
    lkKeyCtx = 1'b0; lkIvCtx = 2'd2; #1;
    chk("R11 cbc iv2", 256'(lkIv), 256'(iv2));
    lkIvCtx = 2'd0; #1;
    chk("R9 R11 cbc iv0", 256'(lkIv), 256'(iv0));
    lkIvCtx = 2'd1; #1;
    chk("R11 cbc iv1 zero", 256'(lkIv), '0);
    lkKeyCtx = 1'b1; lkIvCtx = 2'd0; #1;
    chk("R11 ecb no iv", 256'(lkIv), '0);

    cycleSiv({4'h6, 2'd2, 18'd0, 8'h5A}, 32'h1234_5678);
    #1;
    chk("R12 done", 256'(sivDone), 256'(1));
    chk("R12 iv", 256'(sivIv), 256'(iv2));
    chk("R12 addr", 256'(sivAddr), 256'(40'h5A_1234_5678));
    chk("R12 no reject", 256'(reject), '0);
    cycleSiv({4'h6, 2'd3, 18'd0, 8'h11}, 32'h0);
    #1;
    chk("R12 range no done", 256'(sivDone), '0);
    chk("R12 R13 range reject", 256'(reject), 256'(1));

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule